// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the configuration front end of an I/O-mapped peripheral cluster. It sits on a simple byte-wide I/O bus and answers at two addresses. The lower address holds an index register and the next address up carries the data of the register that the index points at. Software reaches any register in two steps: it writes the register number to the index address, then reads or writes the data address.

The port starts out closed. It opens only after the index address receives the unlock key byte 0x87 twice in a row. While it is closed, it answers every read with 0xFF and drops every write. Writing the lock key 0xAA to the index address closes the port again.

Once the port is open, some indexes reach global registers. These are the device and vendor identification bytes, a revision byte and a logical-device select. The remaining mapped indexes reach a bank that belongs to the logical device currently selected. Each bank holds an enable bit and a small set of configuration bytes. Every bank is exported in parallel on output vectors, so that the logical devices outside the block can use their settings directly.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is closed, the logical-device select is 0, every device enable and every bank byte is 0, and `io_rvalid` is low.
- R2: Only `io_addr == BASE_ADDR` (index) and `io_addr == BASE_ADDR+1` (data) respond. An access to any other address changes no state and raises no `io_rvalid`.
- R3: The port opens only after two consecutive index writes of 0x87. After a single 0x87 it is still closed.
- R4: While the port is closed, an index write of any value other than 0x87 restarts the key sequence, and no index write loads the index register.
- R5: An index write of 0xAA while the port is open closes it and leaves the index register unchanged.
- R6: While the port is closed, index and data reads return 0xFF and data writes have no effect.
- R7: Index 0x20 reads the device ID high byte and 0x21 its low byte. Index 0x22 reads the revision. Index 0x23 reads 0x19 and 0x24 reads 0x34 (vendor ID 0x1934). All five are read-only.
- R8: Index 0x07 holds the logical-device number. A write keeps the low `LDN_W` bits, and a read returns them zero-extended. The value selects which device bank indexes 0x30 and 0x60 and up reach.
- R9: Bit 0 of index 0x30 is the enable of the selected device and drives `dev_enable[n]` for device n. Bits 7:1 read as 0.
- R10: Indexes 0x60 to 0x60+`BANK_REGS`-1 are the selected device's configuration bytes. Byte k of device n appears on `dev_cfg[(n*BANK_REGS+k)*8 +: 8]`.
- R11: With the port open, an unmapped index reads 0x00, and a write to it changes no output.
- R12: `io_rvalid` is high for exactly the one cycle after a cycle with a responding read, and `io_rdata` then holds the value. An open-port index read returns the index register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe, one cycle per read |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rvalid` is high |
| io_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| dev_enable | output | 2**LDN_W | Enable bit of each logical device |
| dev_cfg | output | 2**LDN_W*BANK_REGS*8 | All bank bytes of all devices, flattened |

## Verification
The state that is hardest to reach is the half-open state, when one unlock key has arrived and the next index write decides the outcome. The outputs do not show this state; only a later key write reveals it. The stimulus sends key, interrupting byte, key for each of the 255 non-key bytes. It then probes with a data read, and a trailing non-key write brings the sequence back to its start. Dropped writes while the port is closed only show up after the port reopens, so each such case is followed by an unlock, and the bank bytes and the index register are read back through the port.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic [1:0] {
    KEY_LOCKED = 2'd0,
    KEY_HALF   = 2'd1,
    KEY_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_UNLOCK    = 8'h87;
  localparam logic [7:0] KEY_LOCK      = 8'hAA;
  localparam logic [7:0] READ_LOCKED   = 8'hFF;

  localparam logic [7:0] IDX_LDN       = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI  = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV       = 8'h22;
  localparam logic [7:0] IDX_VEN_HI    = 8'h23;
  localparam logic [7:0] IDX_VEN_LO    = 8'h24;
  localparam logic [7:0] IDX_ENABLE    = 8'h30;
  localparam logic [7:0] IDX_BANK_BASE = 8'h60;

  typedef struct packed {
    logic       idx_wr;
    logic       idx_rd;
    logic       dat_wr;
    logic       dat_rd;
    logic [7:0] wdata;
  } port_req_t;

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output port_req_t         req
);

  localparam logic [ADDR_W-1:0] IDX_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + ADDR_W'(1);

  logic hit_idx;
  logic hit_dat;

  always_comb begin
    hit_idx    = (io_addr == IDX_ADDR);
    hit_dat    = (io_addr == DAT_ADDR);
    req.idx_wr = io_wr & hit_idx;
    req.idx_rd = io_rd & hit_idx;
    req.dat_wr = io_wr & hit_dat;
    req.dat_rd = io_rd & hit_dat;
    req.wdata  = io_wdata;
  end

endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       load_index
);

  key_state_e state_q;
  key_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      KEY_LOCKED: if (idx_wr) state_d = (wdata == KEY_UNLOCK) ? KEY_HALF : KEY_LOCKED;
      KEY_HALF:   if (idx_wr) state_d = (wdata == KEY_UNLOCK) ? KEY_OPEN : KEY_LOCKED;
      KEY_OPEN:   if (idx_wr && (wdata == KEY_LOCK)) state_d = KEY_LOCKED;
      default:    state_d = KEY_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KEY_LOCKED;
    else        state_q <= state_d;
  end

  assign cfg_open   = (state_q == KEY_OPEN);
  // The index register only follows writes made while the port is open,
  // and the closing key itself is not taken as an index.
  assign load_index = idx_wr & cfg_open & (wdata != KEY_LOCK);

endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter int          LDN_W     = 3,
  parameter logic [15:0] DEVICE_ID = 16'h5A31,
  parameter logic [7:0]  REVISION  = 8'h17,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       index,
  input  logic [LDN_W-1:0] wr_ldn,
  output logic [LDN_W-1:0] ldn,
  output logic [7:0]       rd_data,
  output logic             rd_hit
);

  logic [LDN_W-1:0] ldn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ldn_q <= '0;
    else if (wr_en && index == IDX_LDN)  ldn_q <= wr_ldn;
  end

  assign ldn = ldn_q;

  always_comb begin
    rd_hit  = 1'b1;
    rd_data = 8'h00;
    case (index)
      IDX_LDN:      rd_data = 8'(ldn_q);
      IDX_DEVID_HI: rd_data = DEVICE_ID[15:8];
      IDX_DEVID_LO: rd_data = DEVICE_ID[7:0];
      IDX_REV:      rd_data = REVISION;
      IDX_VEN_HI:   rd_data = VENDOR_ID[15:8];
      IDX_VEN_LO:   rd_data = VENDOR_ID[7:0];
      default:      rd_hit  = 1'b0;
    endcase
  end

endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank
  import sio_cfg_pkg::*;
#(
  parameter int LDN_W     = 3,
  parameter int BANK_REGS = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [7:0]                           index,
  input  logic [7:0]                           wdata,
  input  logic [LDN_W-1:0]                     ldn,
  output logic [(1<<LDN_W)-1:0]                dev_enable,
  output logic [(1<<LDN_W)*BANK_REGS*8-1:0]    dev_cfg,
  output logic [7:0]                           rd_data,
  output logic                                 rd_hit
);

  localparam int         NUM_DEV  = 1 << LDN_W;
  localparam int         OFF_W    = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1;
  localparam logic [8:0] BANK_END = 9'(int'(IDX_BANK_BASE) + BANK_REGS);

  logic             in_bank;
  logic [OFF_W-1:0] bank_off;

  assign in_bank  = (index >= IDX_BANK_BASE) && ({1'b0, index} < BANK_END);
  assign bank_off = OFF_W'(index - IDX_BANK_BASE);

  for (genvar n = 0; n < NUM_DEV; n++) begin : g_dev
    logic       en_q;
    logic [7:0] regs_q [BANK_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0;
        for (int k = 0; k < BANK_REGS; k++) regs_q[k] <= 8'h00;
      end else if (wr_en && ldn == LDN_W'(n)) begin
        if (index == IDX_ENABLE) en_q             <= wdata[0];
        else if (in_bank)        regs_q[bank_off] <= wdata;
      end
    end

    assign dev_enable[n] = en_q;

    for (genvar k = 0; k < BANK_REGS; k++) begin : g_reg
      assign dev_cfg[(n*BANK_REGS+k)*8 +: 8] = regs_q[k];
    end
  end

  // The read path picks the selected byte straight out of the export vector.
  always_comb begin
    rd_hit  = 1'b0;
    rd_data = 8'h00;
    if (index == IDX_ENABLE) begin
      rd_hit  = 1'b1;
      rd_data = {7'b0, dev_enable[ldn]};
    end else if (in_bank) begin
      rd_hit  = 1'b1;
      rd_data = dev_cfg[(int'(ldn)*BANK_REGS + int'(bank_off))*8 +: 8];
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter int              LDN_W     = 3,
  parameter int              BANK_REGS = 4,
  parameter logic [15:0]     DEVICE_ID = 16'h5A31,
  parameter logic [7:0]      REVISION  = 8'h17,
  parameter logic [15:0]     VENDOR_ID = 16'h1934
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [ADDR_W-1:0]                 io_addr,
  input  logic                              io_wr,
  input  logic                              io_rd,
  input  logic [7:0]                        io_wdata,
  output logic [7:0]                        io_rdata,
  output logic                              io_rvalid,
  output logic [(1<<LDN_W)-1:0]             dev_enable,
  output logic [(1<<LDN_W)*BANK_REGS*8-1:0] dev_cfg
);

  port_req_t        req;
  logic             cfg_open;
  logic             load_index;
  logic [7:0]       index_q;
  logic             data_wr_en;
  logic [LDN_W-1:0] ldn;
  logic [7:0]       glob_rd;
  logic             glob_hit;
  logic [7:0]       bank_rd;
  logic             bank_hit;
  logic [7:0]       rd_next;
  logic             rd_any;

  sio_port_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_wdata (io_wdata),
    .req      (req)
  );

  sio_key_fsm u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_wr     (req.idx_wr),
    .wdata      (req.wdata),
    .cfg_open   (cfg_open),
    .load_index (load_index)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          index_q <= 8'h00;
    else if (load_index) index_q <= req.wdata;
  end

  assign data_wr_en = req.dat_wr & cfg_open;

  sio_global_regs #(
    .LDN_W     (LDN_W),
    .DEVICE_ID (DEVICE_ID),
    .REVISION  (REVISION),
    .VENDOR_ID (VENDOR_ID)
  ) u_global (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_wr_en),
    .index   (index_q),
    .wr_ldn  (req.wdata[LDN_W-1:0]),
    .ldn     (ldn),
    .rd_data (glob_rd),
    .rd_hit  (glob_hit)
  );

  sio_ldev_bank #(
    .LDN_W     (LDN_W),
    .BANK_REGS (BANK_REGS)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (data_wr_en),
    .index      (index_q),
    .wdata      (req.wdata),
    .ldn        (ldn),
    .dev_enable (dev_enable),
    .dev_cfg    (dev_cfg),
    .rd_data    (bank_rd),
    .rd_hit     (bank_hit)
  );

  assign rd_any = req.idx_rd | req.dat_rd;

  always_comb begin
    rd_next = READ_LOCKED;
    if (req.idx_rd) begin
      rd_next = cfg_open ? index_q : READ_LOCKED;
    end else if (req.dat_rd && cfg_open) begin
      rd_next = glob_hit ? glob_rd : (bank_hit ? bank_rd : 8'h00);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= 8'h00;
    end else begin
      io_rvalid <= rd_any;
      if (rd_any) io_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
  parameter int              LDN_W     = 3,
  parameter int              BANK_REGS = 4
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [ADDR_W-1:0]                 io_addr,
  input logic                              io_wr,
  input logic                              io_rd,
  input logic [7:0]                        io_wdata,
  input logic [7:0]                        io_rdata,
  input logic                              io_rvalid,
  input logic [(1<<LDN_W)-1:0]             dev_enable,
  input logic [(1<<LDN_W)*BANK_REGS*8-1:0] dev_cfg,
  input logic                              cfg_open
);

  logic at_idx;
  logic at_port;
  assign at_idx  = (io_addr == BASE_ADDR);
  assign at_port = at_idx || (io_addr == BASE_ADDR + ADDR_W'(1));

  // R12: a responding read is answered in the next cycle
  a_r12_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_port) |=> io_rvalid);

  // R2: no answer without a responding read
  a_r2_no_rvalid_off_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && at_port) |=> !io_rvalid);

  // R6: closed port reads back all ones
  a_r6_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && at_port && !cfg_open) |=> (io_rdata == 8'hFF));

  // R6: nothing exported moves while the port is closed
  a_r6_locked_state_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_enable) && $stable(dev_cfg)));

  // R3: opening follows an unlock key write on the index address
  a_r3_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && at_idx && io_wdata == 8'h87));

  // R5: the lock key closes an open port
  a_r5_lock_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && at_idx && io_wdata == 8'hAA) |=> !cfg_open);

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR),
  .LDN_W     (LDN_W),
  .BANK_REGS (BANK_REGS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .io_rvalid  (io_rvalid),
  .dev_enable (dev_enable),
  .dev_cfg    (dev_cfg),
  .cfg_open   (cfg_open)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;

  localparam logic [15:0] BASE  = 16'h002E;
  localparam logic [15:0] IDXA  = BASE;
  localparam logic [15:0] DATA  = BASE + 16'd1;
  localparam int          NDEV  = 8;
  localparam int          NREG  = 4;
  localparam logic [15:0] DEVID = 16'h5A31;
  localparam logic [7:0]  REV   = 8'h17;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [15:0]             io_addr = '0;
  logic                    io_wr = 1'b0;
  logic                    io_rd = 1'b0;
  logic [7:0]              io_wdata = '0;
  logic [7:0]              io_rdata;
  logic                    io_rvalid;
  logic [NDEV-1:0]         dev_enable;
  logic [NDEV*NREG*8-1:0]  dev_cfg;

  int  checks = 0;
  int  errors = 0;
  logic [7:0] rd_v;
  logic       rd_ok;
  logic [NDEV*NREG*8-1:0] snap;

  always #4 clk = ~clk;

  sio_cfg_port #(
    .ADDR_W(16), .BASE_ADDR(BASE), .LDN_W(3), .BANK_REGS(NREG),
    .DEVICE_ID(DEVID), .REVISION(REV), .VENDOR_ID(16'h1934)
  ) u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .dev_enable(dev_enable), .dev_cfg(dev_cfg)
  );

  function automatic logic [7:0] pat(int n, int k);
    return 8'(n*37 + k*11 + 3);
  endfunction

  function automatic logic en_of(int n);
    return ((n % 3) == 0);
  endfunction

  // Expected open-port data read with device n selected
  function automatic logic [7:0] exp_reg(int idx, int n);
    if (idx == 'h07) return 8'(n);
    if (idx == 'h20) return DEVID[15:8];
    if (idx == 'h21) return DEVID[7:0];
    if (idx == 'h22) return REV;
    if (idx == 'h23) return 8'h19;
    if (idx == 'h24) return 8'h34;
    if (idx == 'h30) return {7'b0, en_of(n)};
    if (idx >= 'h60 && idx < 'h60 + NREG) return pat(n, idx - 'h60);
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata; v = io_rvalid;
  endtask

  task automatic cfg_read(input logic [7:0] idx, output logic [7:0] d);
    logic v;
    bus_write(IDXA, idx);
    bus_read(DATA, d, v);
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    bus_write(IDXA, idx);
    bus_write(DATA, d);
  endtask

  task automatic unlock();
    bus_write(IDXA, 8'h87);
    bus_write(IDXA, 8'h87);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 enables", 32'(dev_enable), 0);
    chk("R1 cfg zero", 32'(dev_cfg == '0), 1);
    chk("R1 rvalid low", 32'(io_rvalid), 0);
    bus_read(DATA, rd_v, rd_ok);
    chk("R1 closed data read", 32'(rd_v), 32'hFF);
    chk("R12 rvalid after read", 32'(rd_ok), 1);
    @(negedge clk);
    chk("R12 rvalid one cycle", 32'(io_rvalid), 0);
    bus_read(IDXA, rd_v, rd_ok);
    chk("R6 closed index read", 32'(rd_v), 32'hFF);

    // R2 keys at a wrong address do nothing, reads there get no answer
    bus_write(BASE + 16'd2, 8'h87);
    bus_write(BASE - 16'd1, 8'h87);
    bus_read(BASE + 16'd2, rd_v, rd_ok);
    chk("R2 no rvalid off port", 32'(rd_ok), 0);
    bus_read(DATA, rd_v, rd_ok);
    chk("R2 still closed", 32'(rd_v), 32'hFF);

    // R3 one key is not enough
    bus_write(IDXA, 8'h87);
    bus_read(DATA, rd_v, rd_ok);
    chk("R3 half open reads ff", 32'(rd_v), 32'hFF);
    bus_write(IDXA, 8'h00);

    // R4 every interrupting byte restarts the sequence
    for (int v = 0; v < 256; v++) begin
      if (v == 'h87) continue;
      bus_write(IDXA, 8'h87);
      bus_write(IDXA, 8'(v));
      bus_write(IDXA, 8'h87);
      bus_read(DATA, rd_v, rd_ok);
      chk($sformatf("R4 interrupt %0h", v), 32'(rd_v), 32'hFF);
      bus_write(IDXA, 8'h00);
    end

    // R3 two consecutive keys open; R7 identification
    unlock();
    cfg_read(8'h20, rd_v); chk("R7 devid hi", 32'(rd_v), 32'(DEVID[15:8]));
    cfg_read(8'h21, rd_v); chk("R7 devid lo", 32'(rd_v), 32'(DEVID[7:0]));
    cfg_read(8'h22, rd_v); chk("R7 revision", 32'(rd_v), 32'(REV));
    cfg_read(8'h23, rd_v); chk("R7 vendor hi", 32'(rd_v), 32'h19);
    cfg_read(8'h24, rd_v); chk("R7 vendor lo", 32'(rd_v), 32'h34);
    cfg_write(8'h20, 8'h00);
    cfg_write(8'h24, 8'h00);
    cfg_read(8'h20, rd_v); chk("R7 read-only hi", 32'(rd_v), 32'(DEVID[15:8]));
    cfg_read(8'h24, rd_v); chk("R7 read-only lo", 32'(rd_v), 32'h34);

    // R8 R9 R10 fill every device bank
    for (int n = 0; n < NDEV; n++) begin
      cfg_write(8'h07, 8'hF8 | 8'(n));
      cfg_read(8'h07, rd_v);
      chk($sformatf("R8 select %0d", n), 32'(rd_v), 32'(n));
      for (int k = 0; k < NREG; k++) cfg_write(8'(8'h60 + k), pat(n, k));
      cfg_write(8'h30, 8'hFE | 8'(en_of(n)));
      cfg_read(8'h30, rd_v);
      chk($sformatf("R9 enable read %0d", n), 32'(rd_v), 32'(en_of(n)));
    end
    for (int n = 0; n < NDEV; n++) begin
      chk($sformatf("R9 dev_enable %0d", n), 32'(dev_enable[n]), 32'(en_of(n)));
      for (int k = 0; k < NREG; k++)
        chk($sformatf("R10 export %0d/%0d", n, k), 32'(dev_cfg[(n*NREG+k)*8 +: 8]), 32'(pat(n, k)));
    end
    for (int n = 0; n < NDEV; n++) begin
      cfg_write(8'h07, 8'(n));
      for (int k = 0; k < NREG; k++) begin
        cfg_read(8'(8'h60 + k), rd_v);
        chk($sformatf("R8 bank read %0d/%0d", n, k), 32'(rd_v), 32'(pat(n, k)));
      end
    end

    // R11 full index sweep with device 3 selected
    cfg_write(8'h07, 8'h03);
    for (int i = 0; i < 256; i++) begin
      if (i == 'hAA) continue;
      cfg_read(8'(i), rd_v);
      chk($sformatf("R11 index %0h", i), 32'(rd_v), 32'(exp_reg(i, 3)));
    end
    snap = dev_cfg;
    cfg_write(8'h31, 8'h5A);
    cfg_write(8'h64, 8'h5A);
    cfg_write(8'hFF, 8'h5A);
    chk("R11 unmapped write cfg", 32'(dev_cfg == snap), 1);
    chk("R11 unmapped write en", 32'(dev_enable), 32'(8'b0100_1001));

    // R12 open index read returns the index register
    bus_write(IDXA, 8'h61);
    bus_read(IDXA, rd_v, rd_ok);
    chk("R12 index readback", 32'(rd_v), 32'h61);

    // R5 lock key closes, index kept; R6 closed writes dropped
    bus_write(IDXA, 8'hAA);
    bus_read(DATA, rd_v, rd_ok);
    chk("R5 closed after lock", 32'(rd_v), 32'hFF);
    bus_write(DATA, 8'h00);
    bus_write(IDXA, 8'h30);
    bus_write(DATA, 8'h00);
    chk("R6 closed write cfg", 32'(dev_cfg == snap), 1);
    chk("R6 closed write en", 32'(dev_enable), 32'(8'b0100_1001));
    unlock();
    bus_read(IDXA, rd_v, rd_ok);
    chk("R4 index not loaded while closed", 32'(rd_v), 32'h61);
    bus_read(DATA, rd_v, rd_ok);
    chk("R6 bank byte kept", 32'(rd_v), 32'(pat(3, 1)));

    // R1 reset again from a busy state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re-reset enables", 32'(dev_enable), 0);
    chk("R1 re-reset cfg", 32'(dev_cfg == '0), 1);
    bus_read(DATA, rd_v, rd_ok);
    chk("R1 re-reset closed", 32'(rd_v), 32'hFF);
    unlock();
    cfg_read(8'h07, rd_v);
    chk("R1 re-reset select", 32'(rd_v), 0);

    summary();
    $finish;
  end

endmodule